// File: doc/BRIEF.md
# Nonvolatile store/recall controller

This controller decides when a memory leaves normal SRAM service and enters a nonvolatile transfer, and which transfer it runs. A STORE copies the whole array into shadow storage in two timed phases, erase then program. A RECALL copies shadow storage back into the array in one timed restore phase. While either transfer runs, the SRAM side is turned off and the block reports itself busy. The analog parts are reduced to input flags: a supply-low indicator, a power-on pulse and an active-low hardware store line. The transfer durations are fixed cycle counts set by parameters.

A write-since-store flag keeps stores from running when nothing needs saving. Stores started by a falling supply or by the external store line run only when that flag is set. A software store always runs. A low supply also arms a recall, and that recall runs when the supply comes back up. A request that arrives during a transfer is held and runs after the transfer ends. When a store and a recall are both waiting, the store runs first.

Top module: `nvsr_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, every output is 0.
- R2: `sram_off` is 1 in every cycle where `busy` is 1. It is also 1 in every cycle that follows a cycle in which `hsb_n_in` was 0, whether or not a store runs.
- R3: A rising edge on `supply_low` queues a STORE only if a completed write has occurred since the last STORE finished. If not, no phase strobe rises.
- R4: A falling edge on `hsb_n_in` (0 means request) queues a STORE only if the write-since-store flag is set. If the flag is clear, the only effect is that `sram_off` stays high until one cycle after the line returns to 1.
- R5: A pulse on `sw_store` always queues a STORE, even when no write has occurred.
- R6: A STORE starts two cycles after the cycle in which its request was applied. `erase_stb` is high for ERASE_CYC cycles, then `prog_stb` is high for PROG_CYC cycles. `busy`, `sram_off` and `hsb_drive_low` are 1 across both phases. Exactly one phase strobe is high at any time.
- R7: A `wr_done` pulse sets the write-since-store flag only in cycles where `sram_off` is 0. The flag is cleared when the program phase ends.
- R8: A `por` pulse or a `sw_recall` pulse queues a RECALL. A RECALL starts two cycles after the request and holds `restore_stb` and `busy` high for RESTORE_CYC cycles. `hsb_drive_low` stays 0 during a RECALL.
- R9: A rising edge on `supply_low` arms a recall. The next falling edge on `supply_low` queues a RECALL and disarms it.
- R10: A request that arrives during a transfer is held. It starts after exactly one idle cycle once the transfer ends. When a STORE and a RECALL are both waiting, the STORE runs first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| supply_low | input | 1 | 1 while the supply is below the switch threshold |
| por | input | 1 | One-cycle power-on pulse |
| hsb_n_in | input | 1 | External hardware store line, 0 = request |
| sw_store | input | 1 | One-cycle software store trigger |
| sw_recall | input | 1 | One-cycle software recall trigger |
| wr_done | input | 1 | One-cycle pulse for each completed SRAM write |
| sram_off | output | 1 | SRAM read and write disabled |
| busy | output | 1 | A transfer is in progress |
| erase_stb | output | 1 | Store erase phase active |
| prog_stb | output | 1 | Store program phase active |
| restore_stb | output | 1 | Recall restore phase active |
| hsb_drive_low | output | 1 | Drive the store line low during a STORE |

## Verification
The hardest case to reach from the ports is a write that lands while the SRAM is disabled. Such a write must leave the write-since-store flag clear, and that flag cannot be read directly. The stimulus pulses `wr_done` in the middle of a software store's erase phase. It then pulls `hsb_n_in` low and expects only `sram_off` to rise, with no erase phase. The held-request path is reached the same way: a recall trigger is fired in the middle of a store, and a recall is expected after one idle cycle.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ERASE   = 2'd1,
    ST_PROG    = 2'd2,
    ST_RESTORE = 2'd3
  } nvsr_state_e;
endpackage

// File: rtl/nvsr_timer.sv
module nvsr_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R6: phase lengths depend on a steady one-per-cycle count
  assert_count_down_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_load_takes_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/nvsr_req.sv
module nvsr_req (
  input  logic clk,
  input  logic rst,
  input  logic supply_low,
  input  logic por,
  input  logic hsb_n_in,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic wr_done,
  input  logic sram_off,
  input  logic take_store,
  input  logic take_recall,
  input  logic store_done,
  output logic store_pend,
  output logic recall_pend,
  output logic hsb_low
);
  logic sup_q, dirty_q, armed_q, st_pend_q, rc_pend_q, hsb_low_q;
  logic sup_rise, sup_fall, hsb_fall, store_req, recall_req;

  assign sup_rise   = supply_low & ~sup_q;
  assign sup_fall   = ~supply_low & sup_q;
  assign hsb_fall   = ~hsb_n_in & ~hsb_low_q;
  assign store_req  = sw_store | ((sup_rise | hsb_fall) & dirty_q);
  assign recall_req = por | sw_recall | (sup_fall & armed_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_q     <= 1'b0;
      hsb_low_q <= 1'b0;
      dirty_q   <= 1'b0;
      armed_q   <= 1'b0;
      st_pend_q <= 1'b0;
      rc_pend_q <= 1'b0;
    end else begin
      sup_q     <= supply_low;
      hsb_low_q <= ~hsb_n_in;
      if (store_done)               dirty_q <= 1'b0;
      else if (wr_done && !sram_off) dirty_q <= 1'b1;
      if (sup_rise)      armed_q <= 1'b1;
      else if (sup_fall) armed_q <= 1'b0;
      if (store_req)       st_pend_q <= 1'b1;
      else if (take_store) st_pend_q <= 1'b0;
      if (recall_req)       rc_pend_q <= 1'b1;
      else if (take_recall) rc_pend_q <= 1'b0;
    end
  end

  assign store_pend  = st_pend_q;
  assign recall_pend = rc_pend_q;
  assign hsb_low     = hsb_low_q;

  assert_clean_no_store_R3: assert property (@(posedge clk) disable iff (rst)
    (sup_rise && !dirty_q && !sw_store && !hsb_fall && !st_pend_q) |=> !st_pend_q);
  assert_sw_store_queued_R5: assert property (@(posedge clk) disable iff (rst)
    sw_store |=> st_pend_q);
  assert_dirty_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    store_done |=> !dirty_q);
  assert_recall_armed_R9: assert property (@(posedge clk) disable iff (rst)
    (sup_fall && armed_q) |=> (rc_pend_q && !armed_q));
endmodule

// File: rtl/nvsr_ctrl.sv
module nvsr_ctrl #(
  parameter int ERASE_CYC   = 16,
  parameter int PROG_CYC    = 32,
  parameter int RESTORE_CYC = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low,
  input  logic por,
  input  logic hsb_n_in,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic wr_done,
  output logic sram_off,
  output logic busy,
  output logic erase_stb,
  output logic prog_stb,
  output logic restore_stb,
  output logic hsb_drive_low
);
  import nvsr_pkg::*;

  localparam int MAX_EP = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int MAXC   = (MAX_EP > RESTORE_CYC) ? MAX_EP : RESTORE_CYC;
  localparam int CW     = $clog2(MAXC + 1);
  localparam logic [CW-1:0] E_LD = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] P_LD = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] R_LD = CW'(RESTORE_CYC - 1);

  nvsr_state_e state_q, state_d;
  logic store_pend, recall_pend, hsb_low;
  logic take_store, take_recall, store_done;
  logic t_load, t_done;
  logic [CW-1:0] t_val;

  nvsr_req u_req (
    .clk(clk), .rst(rst), .supply_low(supply_low), .por(por),
    .hsb_n_in(hsb_n_in), .sw_store(sw_store), .sw_recall(sw_recall),
    .wr_done(wr_done), .sram_off(sram_off), .take_store(take_store),
    .take_recall(take_recall), .store_done(store_done),
    .store_pend(store_pend), .recall_pend(recall_pend), .hsb_low(hsb_low)
  );

  nvsr_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
  );

  always_comb begin
    state_d     = state_q;
    take_store  = 1'b0;
    take_recall = 1'b0;
    store_done  = 1'b0;
    t_load      = 1'b0;
    t_val       = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (store_pend) begin
          state_d    = ST_ERASE;
          take_store = 1'b1;
          t_load     = 1'b1;
          t_val      = E_LD;
        end else if (recall_pend) begin
          state_d     = ST_RESTORE;
          take_recall = 1'b1;
          t_load      = 1'b1;
          t_val       = R_LD;
        end
      end
      ST_ERASE: if (t_done) begin
        state_d = ST_PROG;
        t_load  = 1'b1;
        t_val   = P_LD;
      end
      ST_PROG: if (t_done) begin
        state_d    = ST_IDLE;
        store_done = 1'b1;
      end
      ST_RESTORE: if (t_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign erase_stb     = (state_q == ST_ERASE);
  assign prog_stb      = (state_q == ST_PROG);
  assign restore_stb   = (state_q == ST_RESTORE);
  assign busy          = (state_q != ST_IDLE);
  assign hsb_drive_low = erase_stb | prog_stb;
  assign sram_off      = busy | hsb_low;

  assert_one_phase_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({erase_stb, prog_stb, restore_stb}));
  assert_erase_then_prog_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_stb) |-> $past(erase_stb));
  assert_start_has_request_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(store_pend || recall_pend));
  assert_store_first_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && store_pend) |=> erase_stb);
endmodule

// File: tb/sim_nvsr_ctrl.sv
module sim_nvsr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int EC = 3, PC = 4, RC = 5;
  // output vector order: {sram_off, busy, erase, prog, restore, hsb_drive_low}
  localparam logic [5:0] V_IDLE = 6'b000000;
  localparam logic [5:0] V_OFF  = 6'b100000;
  localparam logic [5:0] V_ERS  = 6'b111001;
  localparam logic [5:0] V_PRG  = 6'b110101;
  localparam logic [5:0] V_RST  = 6'b110010;

  logic clk = 1'b0, rst = 1'b1;
  logic supply_low = 0, por = 0, hsb_n_in = 1, sw_store = 0, sw_recall = 0, wr_done = 0;
  logic sram_off, busy, erase_stb, prog_stb, restore_stb, hsb_drive_low;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  typedef struct { logic [5:0] exp; string tag; } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvsr_ctrl #(.ERASE_CYC(EC), .PROG_CYC(PC), .RESTORE_CYC(RC)) u0 (
    .clk(clk), .rst(rst), .supply_low(supply_low), .por(por), .hsb_n_in(hsb_n_in),
    .sw_store(sw_store), .sw_recall(sw_recall), .wr_done(wr_done),
    .sram_off(sram_off), .busy(busy), .erase_stb(erase_stb), .prog_stb(prog_stb),
    .restore_stb(restore_stb), .hsb_drive_low(hsb_drive_low));

  // monitor: compare every observed cycle against the scoreboard
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t it;
      logic [5:0] got;
      it  = sb.pop_front();
      got = {sram_off, busy, erase_stb, prog_stb, restore_stb, hsb_drive_low};
      n_tests++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s: outputs %b expected %b at %0t", it.tag, got, it.exp, $time);
      end
    end
  end

  task automatic tick(input logic [5:0] e, input string tag);
    exp_t it;
    @(posedge clk); #1;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic store_seq(input string tag);
    for (int i = 0; i < EC; i++) tick(V_ERS, tag);
    for (int i = 0; i < PC; i++) tick(V_PRG, tag);
  endtask

  task automatic recall_seq(input string tag);
    for (int i = 0; i < RC; i++) tick(V_RST, tag);
  endtask

  task automatic write_pulse(input string tag);
    wr_done = 1; tick(V_IDLE, tag); wr_done = 0; tick(V_IDLE, tag);
  endtask

  initial begin
    tick(V_IDLE, "R1"); tick(V_IDLE, "R1");
    rst = 0; tick(V_IDLE, "R1");

    // R8 power-on recall
    por = 1; tick(V_IDLE, "R8"); por = 0;
    recall_seq("R8"); tick(V_IDLE, "R8");

    // R3 clean supply drop: no store; R9 recall on supply return
    supply_low = 1; tick(V_IDLE, "R3");
    tick(V_IDLE, "R3"); tick(V_IDLE, "R3"); tick(V_IDLE, "R3");
    supply_low = 0; tick(V_IDLE, "R9");
    recall_seq("R9"); tick(V_IDLE, "R9");

    // R3/R7 dirty supply drop stores, then R9 recall
    write_pulse("R7");
    supply_low = 1; tick(V_IDLE, "R3");
    store_seq("R3"); tick(V_IDLE, "R3");
    supply_low = 0; tick(V_IDLE, "R9");
    recall_seq("R9"); tick(V_IDLE, "R9");

    // R4 clean HSB low: only disables SRAM; R7 flag was cleared by the store
    hsb_n_in = 0;
    for (int i = 0; i < 4; i++) tick(V_OFF, "R4");
    hsb_n_in = 1; tick(V_IDLE, "R4"); tick(V_IDLE, "R2");

    // R5 software store with clean flag
    sw_store = 1; tick(V_IDLE, "R5"); sw_store = 0;
    store_seq("R5"); tick(V_IDLE, "R5");

    // R7 a write while busy is ignored
    sw_store = 1; tick(V_IDLE, "R7"); sw_store = 0;
    tick(V_ERS, "R7"); wr_done = 1; tick(V_ERS, "R7"); wr_done = 0; tick(V_ERS, "R7");
    for (int i = 0; i < PC; i++) tick(V_PRG, "R7");
    tick(V_IDLE, "R7");
    hsb_n_in = 0;
    for (int i = 0; i < 3; i++) tick(V_OFF, "R7");
    hsb_n_in = 1; tick(V_IDLE, "R7"); tick(V_IDLE, "R7");

    // R4 dirty HSB low stores; R2 line held low keeps SRAM off afterwards
    write_pulse("R4");
    hsb_n_in = 0; tick(V_OFF, "R4");
    store_seq("R4");
    tick(V_OFF, "R2"); hsb_n_in = 1; tick(V_IDLE, "R2");

    // R10 recall requested during a store runs after one idle cycle
    sw_store = 1; tick(V_IDLE, "R10"); sw_store = 0;
    tick(V_ERS, "R10"); sw_recall = 1; tick(V_ERS, "R10"); sw_recall = 0; tick(V_ERS, "R10");
    for (int i = 0; i < PC; i++) tick(V_PRG, "R10");
    tick(V_IDLE, "R10"); recall_seq("R10"); tick(V_IDLE, "R10");

    // R10 simultaneous requests: store first
    sw_store = 1; sw_recall = 1; tick(V_IDLE, "R10"); sw_store = 0; sw_recall = 0;
    store_seq("R10"); tick(V_IDLE, "R10"); recall_seq("R10"); tick(V_IDLE, "R10");

    // R8 software recall alone
    sw_recall = 1; tick(V_IDLE, "R8"); sw_recall = 0;
    recall_seq("R8"); tick(V_IDLE, "R8");

    @(negedge clk); #1;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule